// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining two predictors. The first looks only at the outcomes of the most recent branches in the whole program. It keeps them in a global outcome history register and uses that value to address a table of 2-bit saturating counters. The second is two-level and looks at the past of one branch. The low bits of the branch address pick an entry in a table of per-branch outcome histories, and the history read there addresses a table of 3-bit saturating counters. A third table of 2-bit counters, also addressed by the global history, chooses which of the two component predictions becomes the final answer.

The fetch stage presents a branch address on the lookup port. In the same cycle it receives the final prediction and both component predictions. When the branch resolves, the pipeline returns the address, the real outcome and the two component predictions it was given on the update port. The update trains both components and trains the chooser where the components disagreed. It then shifts the outcome into the global history and into the addressed local history entry. The lookup port always reflects the state left by updates of earlier cycles. History is not speculative, and no recovery is done.

All table sizes follow from three width parameters. `GHIST_W=12`, `LHT_AW=10` and `LHIST_W=10` give the full configuration: 4096 chooser counters, 4096 global counters, 1024 local histories of 10 bits and 1024 local 3-bit counters, 29 Kbit in total. The default parameters select a reduced configuration with the same structure.

Top module: `hybrid_dir_pred`

## Requirements
- R1: After reset all global counters hold 1, all chooser counters hold 2, all local counters hold 3, and all histories are zero. Every lookup therefore returns not-taken on all three prediction outputs until the first update.
- R2: The global history shifts left by one on each update, with the new outcome entering bit 0. Bit i is 1 when the i-th most recent branch was taken.
- R3: The global component is a table of 2^GHIST_W 2-bit counters addressed by the global history. It predicts taken when the counter is 2 or 3. An update increments the counter on taken and decrements it on not-taken, saturating at 0 and 3.
- R4: The local history table has 2^LHT_AW entries addressed by the low LHT_AW bits of the branch address. An update shifts the outcome into bit 0 of the addressed entry only.
- R5: The local component is a table of 2^LHIST_W 3-bit counters addressed by the selected local history. It predicts taken when the counter is 4 or more. It counts up on taken and down on not-taken, saturating at 0 and 7.
- R6: The chooser is a table of 2^GHIST_W 2-bit counters addressed by the global history. A value of 2 or 3 selects the global prediction and 0 or 1 selects the local one. It changes only when the two returned component predictions differ: up when the global one matched the outcome, down otherwise, saturating at 0 and 3.
- R7: The final prediction equals the component prediction chosen by the chooser. When both components agree, it equals their common value.
- R8: An update changes lookup results from the next cycle on. A lookup in the same cycle as an update sees the state from before that update.
- R9: With the update-valid input low, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Final taken prediction |
| lk_glob_pred | output | 1 | Global component prediction |
| lk_loc_pred | output | 1 | Local component prediction |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_glob_pred | input | 1 | Global prediction given earlier for this branch |
| up_loc_pred | input | 1 | Local prediction given earlier for this branch |

## Verification
A reduced configuration is driven with several outcome patterns. A long all-taken run and an all-not-taken run on one address push every counter against its limits, which separates correct saturation from wrap-around. A taken-taken-taken-not loop and a strictly alternating branch are patterns that only the local component can learn, and they force the chooser to move away from its global default. A pseudo-random stream over addresses whose upper bits exceed the local table range covers index aliasing, disagreement training and idle cycles with junk update data, all checked against an arithmetic model of the three tables.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

  // Which component the chooser counter points at (its MSB).
  typedef enum logic {
    SEL_LOCAL  = 1'b0,
    SEL_GLOBAL = 1'b1
  } src_sel_e;

  function automatic logic pick_pred(input src_sel_e sel, input logic g, input logic l);
    return (sel == SEL_GLOBAL) ? g : l;
  endfunction

endpackage

// File: rtl/hdp_ctr_table.sv
// Table of saturating counters: one combinational read port and one
// read-modify-write training port.
module hdp_ctr_table #(
  parameter int AW      = 4,
  parameter int CW      = 2,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [CW-1:0] rd_ctr,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_idx,
  input  logic          upd_inc
);

  localparam int            DEPTH    = 1 << AW;
  localparam logic [CW-1:0] CTR_MAX  = '1;
  localparam logic [CW-1:0] CTR_INIT = CW'(RST_VAL);

  logic [CW-1:0] tab_q [DEPTH];
  logic [CW-1:0] cur_ctr;
  logic [CW-1:0] nxt_ctr;

  assign rd_ctr  = tab_q[rd_idx];
  assign cur_ctr = tab_q[upd_idx];

  always_comb begin
    nxt_ctr = cur_ctr;
    if (upd_inc) begin
      if (cur_ctr != CTR_MAX) nxt_ctr = cur_ctr + CW'(1);
    end else begin
      if (cur_ctr != '0) nxt_ctr = cur_ctr - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab_q[i] <= CTR_INIT;
    end else if (upd_en) begin
      tab_q[upd_idx] <= nxt_ctr;
    end
  end

endmodule

// File: rtl/hdp_hist_table.sv
// Per-branch outcome histories with a lookup read port and an update
// port that exposes the addressed entry and shifts a new outcome in.
module hdp_hist_table #(
  parameter int AW = 2,
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [HW-1:0] rd_hist,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic          wr_bit,
  output logic [HW-1:0] wr_cur_hist
);

  localparam int DEPTH = 1 << AW;

  logic [HW-1:0] hist_q [DEPTH];
  logic [HW-1:0] hist_nxt;

  assign rd_hist     = hist_q[rd_idx];
  assign wr_cur_hist = hist_q[wr_idx];

  always_comb begin
    hist_nxt = (wr_cur_hist << 1) | HW'(wr_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= hist_nxt;
    end
  end

endmodule

// File: rtl/hybrid_dir_pred.sv
module hybrid_dir_pred
  import hdp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 10,
  parameter int LHT_AW  = 8,
  parameter int LHIST_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_glob_pred,
  output logic            lk_loc_pred,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_glob_pred,
  input  logic            up_loc_pred
);

  localparam int GCW = 2;
  localparam int LCW = 3;

  logic [GHIST_W-1:0] ghist_q;
  logic [GHIST_W-1:0] ghist_d;
  logic [GCW-1:0]     ch_ctr;
  logic [GCW-1:0]     g_ctr;
  logic [LCW-1:0]     l_ctr;
  logic [LHIST_W-1:0] lk_lhist;
  logic [LHIST_W-1:0] up_lhist;
  logic [LHT_AW-1:0]  lk_lidx;
  logic [LHT_AW-1:0]  up_lidx;
  logic               ch_train;
  logic               ch_inc;
  src_sel_e           sel;

  assign lk_lidx = lk_pc[LHT_AW-1:0];
  assign up_lidx = up_pc[LHT_AW-1:0];

  generate
    if (PC_W > LHT_AW) begin : g_pc_hi
      logic unused_pc_hi;
      assign unused_pc_hi = ^{lk_pc[PC_W-1:LHT_AW], up_pc[PC_W-1:LHT_AW]};
    end
  endgenerate

  // Global outcome history: next-state and register.
  always_comb begin
    ghist_d = ghist_q;
    if (up_valid) ghist_d = (ghist_q << 1) | GHIST_W'(up_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghist_q <= '0;
    else        ghist_q <= ghist_d;
  end

  // Chooser trains only on disagreement, toward the correct component.
  assign ch_train = up_valid && (up_glob_pred != up_loc_pred);
  assign ch_inc   = (up_glob_pred == up_taken);

  hdp_ctr_table #(.AW(GHIST_W), .CW(GCW), .RST_VAL(2)) u_chooser (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (ghist_q),
    .rd_ctr  (ch_ctr),
    .upd_en  (ch_train),
    .upd_idx (ghist_q),
    .upd_inc (ch_inc)
  );

  hdp_ctr_table #(.AW(GHIST_W), .CW(GCW), .RST_VAL(1)) u_glob_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (ghist_q),
    .rd_ctr  (g_ctr),
    .upd_en  (up_valid),
    .upd_idx (ghist_q),
    .upd_inc (up_taken)
  );

  hdp_hist_table #(.AW(LHT_AW), .HW(LHIST_W)) u_loc_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (lk_lidx),
    .rd_hist     (lk_lhist),
    .wr_en       (up_valid),
    .wr_idx      (up_lidx),
    .wr_bit      (up_taken),
    .wr_cur_hist (up_lhist)
  );

  hdp_ctr_table #(.AW(LHIST_W), .CW(LCW), .RST_VAL(3)) u_loc_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lk_lhist),
    .rd_ctr  (l_ctr),
    .upd_en  (up_valid),
    .upd_idx (up_lhist),
    .upd_inc (up_taken)
  );

  assign sel          = src_sel_e'(ch_ctr[GCW-1]);
  assign lk_glob_pred = g_ctr[GCW-1];
  assign lk_loc_pred  = l_ctr[LCW-1];
  assign lk_taken     = pick_pred(sel, lk_glob_pred, lk_loc_pred);

endmodule

// File: rtl/hdp_chk.sv
module hdp_chk #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 10,
  parameter int LHT_AW  = 8,
  parameter int LHIST_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_valid,
  input logic [PC_W-1:0]    up_pc,
  input logic               up_taken,
  input logic [GHIST_W-1:0] ghist_q,
  input logic [LHIST_W-1:0] up_lhist,
  input logic               lk_taken,
  input logic               lk_glob_pred,
  input logic               lk_loc_pred
);

  // R2
  ghist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghist_q[0] == $past(up_taken)));

  // R2
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ((ghist_q >> 1) == ($past(ghist_q) & {1'b0, {(GHIST_W-1){1'b1}}})));

  // R9
  ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist_q));

  // R4
  lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ((up_pc[LHT_AW-1:0] != $past(up_pc[LHT_AW-1:0])) ||
                  (up_lhist == (($past(up_lhist) << 1) | LHIST_W'($past(up_taken))))));

  // R7
  agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred));

endmodule

bind hybrid_dir_pred hdp_chk #(
  .PC_W(PC_W), .GHIST_W(GHIST_W), .LHT_AW(LHT_AW), .LHIST_W(LHIST_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_valid     (up_valid),
  .up_pc        (up_pc),
  .up_taken     (up_taken),
  .ghist_q      (ghist_q),
  .up_lhist     (up_lhist),
  .lk_taken     (lk_taken),
  .lk_glob_pred (lk_glob_pred),
  .lk_loc_pred  (lk_loc_pred)
);

// File: tb/hybrid_dir_pred_bench.sv
`timescale 1ns/1ps
module hybrid_dir_pred_bench;

  localparam int PW = 8;
  localparam int GW = 4;
  localparam int LA = 2;
  localparam int LW = 3;

  logic          clk;
  logic          rst_n;
  logic [PW-1:0] lk_pc;
  logic          lk_taken, lk_glob_pred, lk_loc_pred;
  logic          up_valid;
  logic [PW-1:0] up_pc;
  logic          up_taken, up_glob_pred, up_loc_pred;

  int total;
  int bad;
  bit done;

  // Arithmetic model of the tables.
  int gm [1<<GW];
  int cm [1<<GW];
  int lm [1<<LW];
  int lh [1<<LA];
  int gh;
  int lfsr;

  hybrid_dir_pred #(.PC_W(PW), .GHIST_W(GW), .LHT_AW(LA), .LHIST_W(LW)) u_hybrid_dir_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v, input bit up, input int mx);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  // One lookup plus optional update of the same address in the same cycle.
  task automatic step(input int pc, input bit t, input bit valid, input string tag);
    bit eg, el, ef;
    int li;
    @(negedge clk);
    eg = (gm[gh] >= 2);
    li = lh[pc % (1 << LA)];
    el = (lm[li] >= 4);
    ef = (cm[gh] >= 2) ? eg : el;
    lk_pc        = PW'(pc);
    up_valid     = valid;
    up_pc        = PW'(pc);
    up_taken     = t;
    up_glob_pred = eg;
    up_loc_pred  = el;
    #1;
    // R8: the update is already presented, the lookup must still be pre-update
    chk({tag, " R2/R3 global"}, lk_glob_pred, eg);
    chk({tag, " R4/R5 local"},  lk_loc_pred, el);
    chk({tag, " R6/R7 final"},  lk_taken, ef);
    @(posedge clk);
    if (valid) begin
      gm[gh] = sat(gm[gh], t, 3);
      if (eg != el) cm[gh] = sat(cm[gh], (eg == t), 3);
      lm[li] = sat(lm[li], t, 7);
      lh[pc % (1 << LA)] = ((lh[pc % (1 << LA)] << 1) | int'(t)) & ((1 << LW) - 1);
      gh = ((gh << 1) | int'(t)) & ((1 << GW) - 1);
    end
    #1 up_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    gh = 0; lfsr = 16'hACE1;
    for (int i = 0; i < (1 << GW); i++) begin gm[i] = 1; cm[i] = 2; end
    for (int i = 0; i < (1 << LW); i++) lm[i] = 3;
    for (int i = 0; i < (1 << LA); i++) lh[i] = 0;
    rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0;
    up_taken = 1'b0; up_glob_pred = 1'b0; up_loc_pred = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every address predicts not-taken
    for (int p = 0; p < 8; p++) step(p, 1'b0, 1'b0, "R1 reset");

    // Saturation upward on one address
    for (int i = 0; i < 14; i++) step(0, 1'b1, 1'b1, "all-taken");

    // Loop pattern TTTN: local learns, chooser must move to local
    for (int i = 0; i < 32; i++) step(1, (i % 4) != 3, 1'b1, "loop");

    // Alternating branch
    for (int i = 0; i < 24; i++) step(2, i[0], 1'b1, "alternate");

    // R9: junk update data with valid low must change nothing
    for (int i = 0; i < 8; i++) step(i, 1'b1, 1'b0, "R9 idle");

    // Saturation downward
    for (int i = 0; i < 14; i++) step(3, 1'b0, 1'b1, "all-not-taken");

    // Pseudo-random mix, addresses alias above the local index bits (R4)
    for (int i = 0; i < 600; i++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      step(lfsr & 15, ((lfsr >> 4) & 3) != 0, ((lfsr >> 7) & 7) != 0, "random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule